// File: doc/BRIEF.md
# Syndrome-Based Node Synchroniser

This block decides which of several alignment hypotheses applies to the soft-decision stream at the input of a punctured convolutional decoder. A hypothesis combines a code rate, a framing of the two coded bit streams, and an I/Q phasing, either as received or rotated by 90 degrees. The block receives one syndrome bit per valid cycle, already computed upstream. In the correct state the syndrome bits are almost all zero. In a wrong state ones and zeros arrive about equally often.

The decision is a one-sided sequential test. A one adds a fixed step of 32 to an accumulator. A zero subtracts a programmable decrement, and the result never goes below zero. When the accumulator reaches a scaled threshold, the current hypothesis is rejected, the accumulator is cleared and the next hypothesis is selected. A lock flag is raised once a whole scaled timeout window of syndrome bits passes without a rejection.

Each of the three tuning values can come from its own register field or from a built-in default. The block can sweep every state of every rate (automatic mode), or stay within one rate chosen by software (manual mode).

Top module: `syndrome_node_sync`

## Requirements
- R1: On a valid syndrome bit of 1 the accumulator rises by 32. On a valid bit of 0 it falls by the decrement, and a negative result becomes 0.
- R2: When a valid 1 brings the accumulator to or above the threshold, the sync state advances on that clock edge, the accumulator is cleared and lock is dropped.
- R3: The threshold is the threshold units times 512.
  - With `thr_own`=1 the units come from `thr_reg`. A value of 0 is treated as 1, and values above 32 are treated as 32.
  - With `thr_own`=0 the units are 8.
- R4: The decrement depends on `dec_own`.
  - With `dec_own`=1 it is `dec_reg`, limited to at most 32.
  - With `dec_own`=0 it is a per-rate default: 16, 10, 12, 10 and 8 for rate codes 0 to 4.
- R5: The timeout window is the window units times 2048 valid syndrome bits.
  - With `to_own`=1 the units come from `to_reg`, and a value of 0 is treated as 1.
  - With `to_own`=0 the units are 8.
- R6: When a window ends without a rejection, `locked` rises on the edge that takes the window's last bit, and the accumulator is cleared. Lock then holds until the next state change.
- R7: Every change of sync state or code rate clears `locked` and restarts the timeout window.
- R8: Code rate encoding: 0 = 1/2, 1 = 2/3, 2 = 3/4, 3 = 5/6, 4 = 7/8.
  - These rates have 2, 6, 4, 6 and 8 states, indexed from 0.
  - `rotate` equals bit 0 of the state index: odd states are rotated by 90 degrees.
  - A manual rate code of 5 to 7 is treated as 0.
  - After reset the state is 0, the rate is 0 and lock is low.
- R9: In automatic mode (`auto_rate`=1), a rejection in the last state of a rate moves to state 0 of the next rate code. After 7/8 the next rate is 1/2.
- R10: In manual mode, rejections cycle through the states of the selected rate only. When the selected rate differs from the current rate, the block moves to state 0 of the selected rate on the next clock edge.
- R11: Cycles with `syn_valid` low change neither the accumulator nor the window count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| syn_valid | input | 1 | Syndrome bit present this cycle |
| syn_bit | input | 1 | Syndrome bit |
| dec_reg | input | 6 | Decrement register value |
| thr_reg | input | 6 | Threshold register value, in units of 512 |
| to_reg | input | 8 | Timeout register value, in units of 2048 bits |
| dec_own | input | 1 | 1 selects dec_reg, 0 selects the per-rate default |
| thr_own | input | 1 | 1 selects thr_reg, 0 selects 8 units |
| to_own | input | 1 | 1 selects to_reg, 0 selects 8 units |
| auto_rate | input | 1 | 1 sweeps all rates, 0 stays on manual_rate |
| manual_rate | input | 3 | Rate code used in manual mode |
| sync_state | output | 3 | Current state index within the rate |
| code_rate | output | 3 | Current rate code |
| rotate | output | 1 | Current hypothesis uses 90-degree rotation |
| locked | output | 1 | No rejection for one full timeout window |

## Verification
The accumulator is internal, so its value is seen only through the bit on which the next rejection happens. The stimulus uses runs of ones and zeros whose counts are chosen so that a wrong step, a missing floor, or a decrement that was not limited moves the rejection by at least one bit.

The hardest case to reach is a window that ends while the accumulator is partly filled. The stimulus places the tenth of a run of ones exactly on the 2048th bit of the window. It then shows that fifteen further ones do not cause a rejection, which they would if the accumulator had not been cleared at the window end.

// File: rtl/nsync_pkg.sv
package nsync_pkg;

  localparam int RATE_W    = 3;
  localparam int STATE_W   = 3;
  localparam int NUM_RATES = 5;

  typedef enum logic [RATE_W-1:0] {
    RATE_1_2 = 3'd0,
    RATE_2_3 = 3'd1,
    RATE_3_4 = 3'd2,
    RATE_5_6 = 3'd3,
    RATE_7_8 = 3'd4
  } rate_e;

  // highest state index of each rate
  function automatic logic [STATE_W-1:0] last_state(input logic [RATE_W-1:0] r);
    case (r)
      RATE_1_2: last_state = 3'd1;
      RATE_2_3: last_state = 3'd5;
      RATE_3_4: last_state = 3'd3;
      RATE_5_6: last_state = 3'd5;
      default:  last_state = 3'd7;
    endcase
  endfunction

  // built-in decrement for each rate
  function automatic logic [5:0] dflt_dec(input logic [RATE_W-1:0] r);
    case (r)
      RATE_1_2: dflt_dec = 6'd16;
      RATE_2_3: dflt_dec = 6'd10;
      RATE_3_4: dflt_dec = 6'd12;
      RATE_5_6: dflt_dec = 6'd10;
      default:  dflt_dec = 6'd8;
    endcase
  endfunction

  function automatic logic [RATE_W-1:0] sane_rate(input logic [RATE_W-1:0] r);
    sane_rate = (r > RATE_7_8) ? RATE_1_2 : r;
  endfunction

endpackage

// File: rtl/nsync_sprt.sv
module nsync_sprt #(
  parameter int INC   = 32,
  parameter int DEC_W = 6,
  parameter int ACC_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_val,
  input  logic [DEC_W-1:0] dec_amt,
  input  logic [ACC_W-1:0] thresh,
  input  logic             clear_ext,
  output logic             vote
);

  logic [ACC_W-1:0] acc_q, acc_d, down;
  logic [ACC_W:0]   up;
  logic             acc_en;

  always_comb begin
    up     = {1'b0, acc_q} + (ACC_W+1)'(INC);
    down   = (acc_q > ACC_W'(dec_amt)) ? (acc_q - ACC_W'(dec_amt)) : '0;
    vote   = bit_en & bit_val & (up >= {1'b0, thresh});
    acc_en = bit_en | clear_ext;
    if (clear_ext || vote)
      acc_d = '0;
    else if (bit_val)
      acc_d = up[ACC_W-1:0];
    else
      acc_d = down;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (acc_en)
      acc_q <= acc_d;
  end

  assert_vote_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vote |=> acc_q == '0);
  assert_one_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && bit_val && !vote && !clear_ext) |=> acc_q == $past(acc_q) + ACC_W'(INC));
  assert_zero_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !bit_val && !clear_ext) |=> acc_q <= $past(acc_q));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !clear_ext) |=> $stable(acc_q));

endmodule

// File: rtl/nsync_window.sv
module nsync_window #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             restart,
  input  logic [CNT_W-1:0] win_len,
  output logic             win_last,
  output logic             locked
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lock_q, lock_d, cnt_en;

  always_comb begin
    win_last = bit_en & ~restart & (cnt_q >= win_len - 1'b1);
    cnt_en   = bit_en | restart;
    lock_d   = lock_q;
    if (restart) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else if (win_last) begin
      cnt_d  = '0;
      lock_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;

  assert_restart_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!locked && cnt_q == '0));
  assert_window_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> locked);
  assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !restart) |=> locked);
  assert_idle_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/nsync_hyp.sv
module nsync_hyp
  import nsync_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic               auto_mode,
  input  logic [RATE_W-1:0]  manual_rate,
  output logic [STATE_W-1:0] state_idx,
  output logic [RATE_W-1:0]  rate,
  output logic               reload
);

  logic [STATE_W-1:0] st_q, st_d;
  logic [RATE_W-1:0]  rate_q, rate_d, man_eff;
  logic               hyp_en;

  always_comb begin
    man_eff = sane_rate(manual_rate);
    reload  = ~auto_mode & (rate_q != man_eff);
    hyp_en  = reload | advance;
    st_d    = st_q;
    rate_d  = rate_q;
    if (reload) begin
      st_d   = '0;
      rate_d = man_eff;
    end else if (advance) begin
      if (st_q >= last_state(rate_q)) begin
        st_d = '0;
        if (auto_mode)
          rate_d = (rate_q >= RATE_7_8) ? RATE_1_2 : rate_q + 1'b1;
      end else begin
        st_d = st_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      rate_q <= RATE_1_2;
    end else if (hyp_en) begin
      st_q   <= st_d;
      rate_q <= rate_d;
    end
  end

  assign state_idx = st_q;
  assign rate      = rate_q;

  assert_state_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q <= RATE_7_8) && (st_q <= last_state(rate_q)));
  assert_manual_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !auto_mode && !reload) |=> $stable(rate_q));
  assert_auto_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && auto_mode && rate_q == RATE_7_8 && st_q == 3'd7)
      |=> (rate_q == RATE_1_2 && st_q == '0));

endmodule

// File: rtl/syndrome_node_sync.sv
module syndrome_node_sync
  import nsync_pkg::*;
#(
  parameter int INC       = 32,
  parameter int DEC_W     = 6,
  parameter int DEC_MAX   = 32,
  parameter int THR_W     = 6,
  parameter int THR_MAX   = 32,
  parameter int THR_DFLT  = 8,
  parameter int THR_SHIFT = 9,
  parameter int TO_W      = 8,
  parameter int TO_DFLT   = 8,
  parameter int TO_SHIFT  = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               syn_valid,
  input  logic               syn_bit,
  input  logic [DEC_W-1:0]   dec_reg,
  input  logic [THR_W-1:0]   thr_reg,
  input  logic [TO_W-1:0]    to_reg,
  input  logic               dec_own,
  input  logic               thr_own,
  input  logic               to_own,
  input  logic               auto_rate,
  input  logic [RATE_W-1:0]  manual_rate,
  output logic [STATE_W-1:0] sync_state,
  output logic [RATE_W-1:0]  code_rate,
  output logic               rotate,
  output logic               locked
);

  localparam int ACC_W = $clog2(THR_MAX) + THR_SHIFT + 1;
  localparam int CNT_W = TO_W + TO_SHIFT;
  localparam logic [DEC_W-1:0] DEC_MAX_V  = DEC_W'(DEC_MAX);
  localparam logic [THR_W-1:0] THR_MAX_V  = THR_W'(THR_MAX);
  localparam logic [THR_W-1:0] THR_DFLT_V = THR_W'(THR_DFLT);
  localparam logic [TO_W-1:0]  TO_DFLT_V  = TO_W'(TO_DFLT);

  logic [DEC_W-1:0] dec_amt;
  logic [THR_W-1:0] thr_units;
  logic [TO_W-1:0]  to_units;
  logic [ACC_W-1:0] thresh;
  logic [CNT_W-1:0] win_len;
  logic             vote, reload, win_last, restart;

  // effective tuning values
  always_comb begin
    if (dec_own)
      dec_amt = (dec_reg > DEC_MAX_V) ? DEC_MAX_V : dec_reg;
    else
      dec_amt = DEC_W'(dflt_dec(code_rate));

    if (!thr_own)
      thr_units = THR_DFLT_V;
    else if (thr_reg == '0)
      thr_units = THR_W'(1);
    else if (thr_reg > THR_MAX_V)
      thr_units = THR_MAX_V;
    else
      thr_units = thr_reg;

    if (!to_own)
      to_units = TO_DFLT_V;
    else if (to_reg == '0)
      to_units = TO_W'(1);
    else
      to_units = to_reg;

    thresh  = ACC_W'(thr_units) << THR_SHIFT;
    win_len = CNT_W'(to_units) << TO_SHIFT;
    restart = vote | reload;
  end

  nsync_sprt #(.INC(INC), .DEC_W(DEC_W), .ACC_W(ACC_W)) u_sprt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (syn_valid),
    .bit_val   (syn_bit),
    .dec_amt   (dec_amt),
    .thresh    (thresh),
    .clear_ext (win_last | reload),
    .vote      (vote)
  );

  nsync_window #(.CNT_W(CNT_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (syn_valid),
    .restart  (restart),
    .win_len  (win_len),
    .win_last (win_last),
    .locked   (locked)
  );

  nsync_hyp u_hyp (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (vote),
    .auto_mode   (auto_rate),
    .manual_rate (manual_rate),
    .state_idx   (sync_state),
    .rate        (code_rate),
    .reload      (reload)
  );

  assign rotate = sync_state[0];

  assert_change_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state != $past(sync_state) || code_rate != $past(code_rate)) |-> !locked);

endmodule

// File: tb/syndrome_node_sync_bench.sv
module syndrome_node_sync_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  // vector fields: bit(1) count(12) exp_state(3) exp_rate(3) exp_lock(1)
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 12'd15,   3'd0, 3'd0, 1'b0},
    {1'b1, 12'd1,    3'd1, 3'd0, 1'b0},
    {1'b1, 12'd16,   3'd0, 3'd1, 1'b0},
    {1'b1, 12'd80,   3'd5, 3'd1, 1'b0},
    {1'b1, 12'd16,   3'd0, 3'd2, 1'b0},
    {1'b1, 12'd64,   3'd0, 3'd3, 1'b0},
    {1'b1, 12'd96,   3'd0, 3'd4, 1'b0},
    {1'b1, 12'd112,  3'd7, 3'd4, 1'b0},
    {1'b1, 12'd16,   3'd0, 3'd0, 1'b0},
    {1'b0, 12'd2047, 3'd0, 3'd0, 1'b0},
    {1'b0, 12'd1,    3'd0, 3'd0, 1'b1},
    {1'b1, 12'd10,   3'd0, 3'd0, 1'b1},
    {1'b0, 12'd1,    3'd0, 3'd0, 1'b1},
    {1'b1, 12'd6,    3'd0, 3'd0, 1'b1},
    {1'b1, 12'd1,    3'd1, 3'd0, 1'b0},
    {1'b0, 12'd5,    3'd1, 3'd0, 1'b0},
    {1'b1, 12'd15,   3'd1, 3'd0, 1'b0},
    {1'b1, 12'd1,    3'd0, 3'd1, 1'b0},
    {1'b0, 12'd2038, 3'd0, 3'd1, 1'b0},
    {1'b1, 12'd10,   3'd0, 3'd1, 1'b1},
    {1'b1, 12'd15,   3'd0, 3'd1, 1'b1},
    {1'b1, 12'd1,    3'd1, 3'd1, 1'b0}
  };

  logic       clk, rst_n, syn_valid, syn_bit;
  logic [5:0] dec_reg, thr_reg;
  logic [7:0] to_reg;
  logic       dec_own, thr_own, to_own, auto_rate;
  logic [2:0] manual_rate;
  logic [2:0] sync_state, code_rate;
  logic       rotate, locked;
  int         checks, errors;

  syndrome_node_sync u_syndrome_node_sync (
    .clk(clk), .rst_n(rst_n), .syn_valid(syn_valid), .syn_bit(syn_bit),
    .dec_reg(dec_reg), .thr_reg(thr_reg), .to_reg(to_reg),
    .dec_own(dec_own), .thr_own(thr_own), .to_own(to_own),
    .auto_rate(auto_rate), .manual_rate(manual_rate),
    .sync_state(sync_state), .code_rate(code_rate),
    .rotate(rotate), .locked(locked)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [2:0] es, input logic [2:0] er,
                       input logic el);
    checks++;
    if (sync_state !== es || code_rate !== er || locked !== el || rotate !== es[0]) begin
      errors++;
      $display("FAIL %s: state/rate/lock/rot = %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
               tag, sync_state, code_rate, locked, rotate, es, er, el, es[0]);
    end
  endtask

  task automatic send(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      syn_valid = 1'b1;
      syn_bit   = b;
    end
    @(negedge clk);
    syn_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; syn_valid = 1'b0; syn_bit = 1'b0;
    dec_reg = 6'd16; thr_reg = 6'd1; to_reg = 8'd1;
    dec_own = 1'b1; thr_own = 1'b1; to_own = 1'b1;
    auto_rate = 1'b1; manual_rate = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset R8", 3'd0, 3'd0, 1'b0);

    // table walk: threshold 512, decrement 16, window 2048, automatic sweep
    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][19], int'(VEC[v][18:7]));
      check($sformatf("vector %0d R1 R2 R6 R8 R9", v), VEC[v][6:4], VEC[v][3:1], VEC[v][0]);
    end

    // R11: invalid cycles carrying ones leave the accumulator alone
    syn_bit = 1'b1;
    repeat (300) @(negedge clk);
    send(1'b1, 15);
    check("R11 idle ones ignored", 3'd1, 3'd1, 1'b0);
    send(1'b1, 1);
    check("R1 sixteenth one rejects", 3'd2, 3'd1, 1'b0);

    // R3 default threshold: 8 x 512 = 4096 -> 128 ones
    thr_own = 1'b0;
    send(1'b1, 127);
    check("R3 default thr below", 3'd2, 3'd1, 1'b0);
    send(1'b1, 1);
    check("R3 default thr reached", 3'd3, 3'd1, 1'b0);

    // R3 zero register treated as 1
    thr_own = 1'b1; thr_reg = 6'd0;
    send(1'b1, 15);
    check("R3 zero thr below", 3'd3, 3'd1, 1'b0);
    send(1'b1, 1);
    check("R3 zero thr reached", 3'd4, 3'd1, 1'b0);

    // R3 register above 32 limited to 32 -> 512 ones
    thr_reg = 6'd63;
    send(1'b1, 511);
    check("R3 max thr below", 3'd4, 3'd1, 1'b0);
    send(1'b1, 1);
    check("R3 max thr reached", 3'd5, 3'd1, 1'b0);
    thr_reg = 6'd1;

    // R4 decrement register above 32 limited to 32
    dec_reg = 6'd63;
    send(1'b1, 15);
    send(1'b0, 1);
    send(1'b1, 1);
    check("R4 dec limit no vote", 3'd5, 3'd1, 1'b0);
    send(1'b1, 1);
    check("R4 dec limit vote", 3'd0, 3'd2, 1'b0);

    // R10 manual reload to 7/8, then R4 default decrement 8
    dec_own = 1'b0; auto_rate = 1'b0; manual_rate = 3'd4;
    @(negedge clk);
    check("R10 manual reload", 3'd0, 3'd4, 1'b0);
    send(1'b1, 15);
    send(1'b0, 4);
    send(1'b1, 1);
    check("R4 default dec no vote", 3'd0, 3'd4, 1'b0);
    send(1'b1, 1);
    check("R4 default dec vote", 3'd1, 3'd4, 1'b0);

    // R10 manual wrap within 3/4 (4 states), R8 rotate flag
    manual_rate = 3'd2;
    @(negedge clk);
    send(1'b1, 16);
    check("R8 odd state rotated", 3'd1, 3'd2, 1'b0);
    send(1'b1, 48);
    check("R10 manual wrap keeps rate", 3'd0, 3'd2, 1'b0);

    // R5 zero timeout register treated as 1 window unit
    to_reg = 8'd0;
    send(1'b0, 2047);
    check("R5 zero timeout before end", 3'd0, 3'd2, 1'b0);
    send(1'b0, 1);
    check("R5 zero timeout locks", 3'd0, 3'd2, 1'b1);

    // R7 manual rate change drops lock
    manual_rate = 3'd3;
    @(negedge clk);
    check("R7 reload unlocks", 3'd0, 3'd3, 1'b0);

    // R5 default window 8 x 2048
    to_own = 1'b0;
    send(1'b0, 16383);
    check("R5 default timeout before end", 3'd0, 3'd3, 1'b0);
    send(1'b0, 1);
    check("R5 default timeout locks", 3'd0, 3'd3, 1'b1);

    // R8 manual code 6 treated as 1/2
    manual_rate = 3'd6;
    @(negedge clk);
    check("R8 invalid manual code", 3'd0, 3'd0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule